// File: doc/BRIEF.md
# Binary Popcount Matrix Tile

This block computes one 8x8 tile of a binary matrix product with a reduction depth of 128 bits. Each operand A row and each operand B column is a 128-bit vector of single-bit elements. An output element D[i][j] is formed by bitwise XOR or bitwise AND of A row i with B column j. The set bits of the result are counted and the count is added to a signed 32-bit accumulator word C[i][j].

Software or a neighbouring unit first fills the operand stores through three write ports: A rows, B columns and C words. It then pulses `start` with the wanted combine operation on `op_and`. While `busy` is high the unit produces one result per clock, walking the tile in row-major order. It raises `done` for one cycle once the last element is stored. Results are read back at any time through an indexed combinational read port.

Top module: `bpop_tile`

## Requirements
- R1: After reset `busy` and `done` are low and every D word reads as zero.
- R2: A write with `a_wr` stores `a_wdata` as A row `a_wsel`. A write with `b_wr` stores `b_wdata` as B column `b_wsel`. A write with `c_wr` stores `c_wdata` as C word `c_wsel`, where the element index is i*8+j (i = row, j = column).
- R3: With `op_and` = 0 (XOR) at launch, D[i][j] = C[i][j] + popcount(A_i XOR B_j).
- R4: With `op_and` = 1 (AND) at launch, D[i][j] = C[i][j] + popcount(A_i AND B_j).
- R5: The per-element bit count spans 0 to 128 inclusive. Identical vectors under XOR add 0, and all-ones vectors under AND add 128.
- R6: The final add wraps modulo 2^32 with no saturation. For example, 0x7FFFFFC0 + 128 gives 0x80000040.
- R7: A `start` seen while idle raises `busy` on the next cycle. `busy` then stays high for exactly 64 cycles, and one element is written per cycle in row-major order.
- R8: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after the last element is written.
- R9: `op_and` is sampled only in the launch cycle. A `start` pulse or a change of `op_and` while `busy` is high has no effect on the run or its results.
- R10: `d_rdata` shows D word `d_rsel` combinationally. D words keep their values until a later run rewrites them, even if C words are rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | A row write strobe |
| a_wsel | input | 3 | A row index |
| a_wdata | input | 128 | A row bits |
| b_wr | input | 1 | B column write strobe |
| b_wsel | input | 3 | B column index |
| b_wdata | input | 128 | B column bits |
| c_wr | input | 1 | C word write strobe |
| c_wsel | input | 6 | C element index (i*8+j) |
| c_wdata | input | 32 | C word, signed |
| op_and | input | 1 | Combine select: 0 = XOR, 1 = AND |
| start | input | 1 | Launch pulse, honoured only while idle |
| busy | output | 1 | Tile computation in progress |
| done | output | 1 | One-cycle completion pulse |
| d_rsel | input | 6 | D element index (i*8+j) |
| d_rdata | output | 32 | D word, signed |

## Verification
The assertions assume that the A, B and C stores are not written while `busy` is high. A run reads them element by element, so a mid-run write would give a mix of old and new operands, and nothing in the properties models that. The stimulus therefore loads every operand before the launch pulse and writes new C words only after `done`. While a run is in progress, the only inputs the bench changes are `op_and` and stray `start` pulses. Those are exactly the inputs the unit must ignore at that point.

// File: rtl/bpop_pkg.sv
`timescale 1ns/1ps
package bpop_pkg;
  localparam int unsigned TILE_ROWS = 8;
  localparam int unsigned TILE_COLS = 8;
  localparam int unsigned RED_BITS  = 128;
  localparam int unsigned ACC_W     = 32;
  localparam int unsigned CNT_W     = $clog2(RED_BITS + 1);

  typedef enum logic {
    OP_XOR = 1'b0,
    OP_AND = 1'b1
  } bop_e;

  // bitwise merge of a row and a column before counting
  function automatic logic [RED_BITS-1:0] merge_bits(bop_e op,
                                                     logic [RED_BITS-1:0] r,
                                                     logic [RED_BITS-1:0] c);
    return (op == OP_AND) ? (r & c) : (r ^ c);
  endfunction

  // two's-complement accumulate of an unsigned count, wraps modulo 2^ACC_W
  function automatic logic [ACC_W-1:0] acc_add(logic [ACC_W-1:0] base,
                                               logic [CNT_W-1:0] n);
    return base + {{(ACC_W-CNT_W){1'b0}}, n};
  endfunction
endpackage

// File: rtl/bpop_store.sv
`timescale 1ns/1ps
module bpop_store #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 128,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < int'(N); e++) mem[e] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/bpop_popc.sv
`timescale 1ns/1ps
module bpop_popc #(
  parameter int unsigned W  = 128,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] cnt
);
  localparam int unsigned LG = $clog2(W);

  for (genvar lv = 0; lv <= LG; lv++) begin : g_lvl
    localparam int unsigned NN = W >> lv;
    logic [CW-1:0] s [NN];
    if (lv == 0) begin : g_leaf
      for (genvar k = 0; k < NN; k++) begin : g_b
        assign s[k] = {{(CW-1){1'b0}}, bits[k]};
      end
    end else begin : g_add
      for (genvar k = 0; k < NN; k++) begin : g_p
        assign s[k] = g_lvl[lv-1].s[2*k] + g_lvl[lv-1].s[2*k+1];
      end
    end
  end

  assign cnt = g_lvl[LG].s[0];
endmodule

// File: rtl/bpop_seq.sv
`timescale 1ns/1ps
module bpop_seq #(
  parameter int unsigned ELEMS = 64,
  parameter int unsigned EW    = $clog2(ELEMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic [EW-1:0] step,
  output logic          last
);
  logic          busy_q, done_q;
  logic [EW-1:0] step_q;

  assign launch = start & ~busy_q;
  assign last   = busy_q && (step_q == EW'(ELEMS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= last;
      if (launch) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + EW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign step = step_q;
endmodule

// File: rtl/bpop_tile.sv
`timescale 1ns/1ps
module bpop_tile
  import bpop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_wr,
  input  logic [2:0]           a_wsel,
  input  logic [127:0]         a_wdata,
  input  logic                 b_wr,
  input  logic [2:0]           b_wsel,
  input  logic [127:0]         b_wdata,
  input  logic                 c_wr,
  input  logic [5:0]           c_wsel,
  input  logic [31:0]          c_wdata,
  input  logic                 op_and,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic [5:0]           d_rsel,
  output logic [31:0]          d_rdata
);
  localparam int unsigned RIW   = $clog2(TILE_ROWS);
  localparam int unsigned CIW   = $clog2(TILE_COLS);
  localparam int unsigned ELEMS = TILE_ROWS * TILE_COLS;
  localparam int unsigned EIDXW = RIW + CIW;
  localparam int unsigned KBITS = RED_BITS;
  localparam int unsigned CNTW  = CNT_W;

  // named internal events for the checker
  logic             launch;
  logic             last;
  logic [EIDXW-1:0] step;
  logic [CNTW-1:0]  pc_cnt;
  bop_e             op_q;

  logic [RIW-1:0]   row_sel;
  logic [CIW-1:0]   col_sel;
  logic [KBITS-1:0] a_row, b_col, merged;
  logic [ACC_W-1:0] c_word, d_word;

  bpop_seq #(.ELEMS(ELEMS), .EW(EIDXW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .launch(launch),
    .busy(busy), .done(done), .step(step), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= OP_XOR;
    else if (launch) op_q <= bop_e'(op_and);
  end

  assign row_sel = step[EIDXW-1:CIW];
  assign col_sel = step[CIW-1:0];

  bpop_store #(.N(TILE_ROWS), .W(KBITS), .IW(RIW)) u_astore (
    .clk(clk), .rst_n(rst_n), .we(a_wr), .widx(a_wsel), .wdata(a_wdata),
    .ridx(row_sel), .rdata(a_row)
  );

  bpop_store #(.N(TILE_COLS), .W(KBITS), .IW(CIW)) u_bstore (
    .clk(clk), .rst_n(rst_n), .we(b_wr), .widx(b_wsel), .wdata(b_wdata),
    .ridx(col_sel), .rdata(b_col)
  );

  bpop_store #(.N(ELEMS), .W(ACC_W), .IW(EIDXW)) u_cstore (
    .clk(clk), .rst_n(rst_n), .we(c_wr), .widx(c_wsel), .wdata(c_wdata),
    .ridx(step), .rdata(c_word)
  );

  assign merged = merge_bits(op_q, a_row, b_col);

  bpop_popc #(.W(KBITS), .CW(CNTW)) u_popc (
    .bits(merged), .cnt(pc_cnt)
  );

  assign d_word = acc_add(c_word, pc_cnt);

  bpop_store #(.N(ELEMS), .W(ACC_W), .IW(EIDXW)) u_dstore (
    .clk(clk), .rst_n(rst_n), .we(busy), .widx(step), .wdata(d_word),
    .ridx(d_rsel), .rdata(d_rdata)
  );
endmodule

// File: rtl/bpop_tile_chk.sv
`timescale 1ns/1ps
module bpop_tile_chk #(
  parameter int unsigned ELEMS = 64,
  parameter int unsigned KB    = 128,
  parameter int unsigned EW    = 6,
  parameter int unsigned CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          launch,
  input logic          busy,
  input logic          done,
  input logic [EW-1:0] step,
  input logic          op_q,
  input logic [CW-1:0] pc_cnt
);
  assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && step == '0));

  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_step_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (step == ($past(step) + EW'(1))));

  assert_done_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(step) == EW'(ELEMS - 1)));

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pc_cnt <= CW'(KB)));

  assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));
endmodule

bind bpop_tile bpop_tile_chk #(
  .ELEMS(ELEMS), .KB(KBITS), .EW(EIDXW), .CW(CNTW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .launch(launch), .busy(busy),
  .done(done), .step(step), .op_q(op_q), .pc_cnt(pc_cnt)
);

// File: tb/sim_bpop_tile.sv
`timescale 1ns/1ps
module sim_bpop_tile;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_wr, b_wr, c_wr;
  logic [2:0]   a_wsel, b_wsel;
  logic [127:0] a_wdata, b_wdata;
  logic [5:0]   c_wsel, d_rsel;
  logic [31:0]  c_wdata, d_rdata;
  logic         op_and, start, busy, done;

  always #4 clk = ~clk;  // 125 MHz

  bpop_tile u0 (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_wsel(a_wsel), .a_wdata(a_wdata),
    .b_wr(b_wr), .b_wsel(b_wsel), .b_wdata(b_wdata),
    .c_wr(c_wr), .c_wsel(c_wsel), .c_wdata(c_wdata),
    .op_and(op_and), .start(start), .busy(busy), .done(done),
    .d_rsel(d_rsel), .d_rdata(d_rdata)
  );

  int nvec = 0;
  int nbad = 0;

  logic [127:0] ma [8];
  logic [127:0] mb [8];
  logic [31:0]  mc [64];
  logic [31:0]  dexp [64];

  // behavioural timing model
  bit m_busy = 0;
  bit m_done = 0;
  int m_cnt  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == 63) begin m_busy = 0; m_done = 1; end
        m_cnt++;
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R8 done", {31'd0, done}, {31'd0, m_done});
    end
  end

  function automatic int ones(logic [127:0] v);
    int n = 0;
    for (int i = 0; i < 128; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic load_all();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); a_wr = 1; a_wsel = 3'(i); a_wdata = ma[i];
      b_wr = 1; b_wsel = 3'(i); b_wdata = mb[i];
    end
    @(negedge clk); a_wr = 0; b_wr = 0;
    for (int k = 0; k < 64; k++) begin
      c_wr = 1; c_wsel = 6'(k); c_wdata = mc[k];
      @(negedge clk);
    end
    c_wr = 0;
  endtask

  task automatic run(bit op, bit disturb);
    for (int k = 0; k < 64; k++) begin
      logic [127:0] v;
      v = op ? (ma[k/8] & mb[k%8]) : (ma[k/8] ^ mb[k%8]);
      dexp[k] = mc[k] + 32'(ones(v));
    end
    @(negedge clk); start = 1; op_and = op;
    @(negedge clk); start = 0; op_and = ~op;   // R9: later value ignored
    if (disturb) begin
      repeat (9) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    while (!m_done) @(negedge clk);
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); d_rsel = 6'(k);
      #1 chk(req, d_rdata, dexp[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired R7 got=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 0; a_wr = 0; b_wr = 0; c_wr = 0; a_wsel = 0; b_wsel = 0;
    a_wdata = 0; b_wdata = 0; c_wsel = 0; c_wdata = 0; op_and = 0;
    start = 0; d_rsel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int k = 0; k < 64; k++) dexp[k] = 0;
    read_all("R1 reset D");

    // R2 R3: random operands, XOR
    for (int i = 0; i < 8; i++) begin
      ma[i] = {$urandom, $urandom, $urandom, $urandom};
      mb[i] = {$urandom, $urandom, $urandom, $urandom};
    end
    for (int k = 0; k < 64; k++) mc[k] = $urandom;
    load_all();
    run(1'b0, 1'b0);
    read_all("R3 xor");

    // R4 R9: AND, with stray start and op change mid-run
    run(1'b1, 1'b1);
    read_all("R4 R9 and");

    // R5: count extremes
    for (int i = 0; i < 8; i++) begin
      ma[i] = (i % 2 == 0) ? '1 : {$urandom, $urandom, $urandom, $urandom};
      mb[i] = (i % 2 == 0) ? '1 : ma[i];
    end
    for (int k = 0; k < 64; k++) mc[k] = 32'(k);
    load_all();
    run(1'b1, 1'b0);
    read_all("R5 and all-ones");
    run(1'b0, 1'b0);
    read_all("R5 xor equal");

    // R6: wrap past the signed limits
    for (int i = 0; i < 8; i++) begin ma[i] = '1; mb[i] = '1; end
    for (int k = 0; k < 64; k++)
      mc[k] = (k % 3 == 0) ? 32'h7FFF_FFC0 : (k % 3 == 1) ? 32'hFFFF_FFF0 : 32'h7FFF_FF80;
    load_all();
    run(1'b1, 1'b0);
    read_all("R6 wrap");
    d_rsel = 6'd0; #1 chk("R6 wrap value", d_rdata, 32'h8000_0040);

    // R10: D holds after C is rewritten
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); c_wr = 1; c_wsel = 6'(k); c_wdata = 32'h1234_0000 + 32'(k);
    end
    @(negedge clk); c_wr = 0;
    read_all("R10 hold");

    // R7: back-to-back launch right after done
    for (int k = 0; k < 64; k++) mc[k] = 32'h1234_0000 + 32'(k);
    run(1'b0, 1'b0);
    read_all("R7 R2 relaunch");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule